// File: doc/BRIEF.md
# Modulo Post-Modify Address Generator

This block produces the data-memory address for a small signal-processing controller. It holds two address pointers and two buffer-length registers. Every cycle it drives the current value of one pointer as an 8-bit address to a pair of 256-word memories. When an access is requested, the selected pointer is rewritten at the following clock edge according to a post-modify mode. The modes are plain step up, plain step down, and circular step up or down inside a buffer whose length comes from either length register.

A circular buffer of length N sits on a boundary aligned to B, the smallest power of two at or above N. The offset of a pointer is its value modulo B, and the base is the pointer with that offset cleared. Software loads pointers and lengths through a single register-write port. The instruction decoder and the datapath that consume the address are not part of this block.

Top module: `ptr_agen`

## Requirements
- R1: After a cycle with `rst_n` low, both pointers and both length registers read as 0, so `acc_addr` is 0.
- R2: `acc_addr` always equals the pointer named by `acc_ptr` as held before any update. A post-modify from an access becomes visible from the next clock edge on.
- R3: Mode code 1 with `acc_en` high replaces the pointer by its value plus one, wrapping from 0xFF to 0x00.
- R4: Mode code 2 with `acc_en` high replaces the pointer by its value minus one, wrapping from 0x00 to 0xFF.
- R5: Mode code 3 is a circular step up with N taken from length register `acc_nsel` (0 or 1). If the offset is N-1 or more, the pointer becomes the base. Otherwise it becomes the pointer plus one.
- R6: Mode code 4 is a circular step down with the same N. An offset of 0 gives base + N - 1. Any other offset gives the pointer minus one.
- R7: When the selected length is 0 or 1, modes 3 and 4 leave the pointer unchanged.
- R8: Mode code 0, codes 5 to 7, and any cycle with `acc_en` low leave the pointer unchanged.
- R9: `wr_en` high loads `wr_data` at the next edge. With `wr_kind` 0 it goes to pointer `wr_idx`; with `wr_kind` 1 it goes to length register `wr_idx`. A pointer write wins over a same-cycle access to that same pointer.
- R10: An access changes only the pointer named by `acc_ptr`. A write to the other pointer in the same cycle also takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 1 | 0 = pointer, 1 = length register |
| wr_idx | input | 1 | Which pointer or length register to write |
| wr_data | input | 8 | Value written |
| acc_en | input | 1 | Access this cycle; enables the post-modify |
| acc_ptr | input | 1 | Pointer used for the access |
| acc_mode | input | 3 | Post-modify code (0 hold, 1 up, 2 down, 3 circular up, 4 circular down) |
| acc_nsel | input | 1 | Length register used by circular modes |
| acc_addr | output | 8 | Current value of the selected pointer |

## Verification
The bound checker watches every cycle for the following: the zero state after reset, the plain step up and step down of the accessed pointer, the hold codes, write priority on a pointer, and the fact that the pointer not being accessed stays untouched. Circular wrapping depends on the length value, the alignment and the offset together, so only the bench scenarios show it. They do this by walking pointers through several buffer lengths against an independent model and by probing lengths of 0 and 1. The bench also covers the same-cycle write and access cases.

// File: rtl/agen_pkg.sv
// Shared constants for the post-modify address generator.
// Assumes a 3-bit mode code; codes above 4 are treated as hold.
package agen_pkg;
    localparam logic [2:0] MD_HOLD    = 3'd0;
    localparam logic [2:0] MD_INC     = 3'd1;
    localparam logic [2:0] MD_DEC     = 3'd2;
    localparam logic [2:0] MD_INC_MOD = 3'd3;
    localparam logic [2:0] MD_DEC_MOD = 3'd4;
endpackage

// File: rtl/agen_step.sv
// Next-pointer arithmetic for one access.
// Assumes circular buffers are aligned to the next power of two at or
// above their length; length 0 or 1 disables circular stepping.
module agen_step #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] cur,
    input  logic [2:0]    mode,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] nxt
);
    import agen_pkg::*;

    logic [AW-1:0] last_off;
    logic [AW-1:0] msk;
    logic [AW-1:0] base;
    logic [AW-1:0] off;
    logic          mod_ok;

    // Derive the alignment mask, base and offset of the circular buffer.
    always_comb begin
        last_off = len - 1'b1;
        msk      = last_off;
        for (int s = 1; s < AW; s = s * 2) begin
            msk = msk | (msk >> s);
        end
        base   = cur & ~msk;
        off    = cur & msk;
        mod_ok = (len > 1);
    end

    // Select the updated pointer for the requested mode.
    always_comb begin
        case (mode)
            MD_INC:     nxt = cur + 1'b1;
            MD_DEC:     nxt = cur - 1'b1;
            MD_INC_MOD: nxt = !mod_ok ? cur : ((off >= last_off) ? base : cur + 1'b1);
            MD_DEC_MOD: nxt = !mod_ok ? cur : ((off == '0) ? (base | last_off) : cur - 1'b1);
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/agen_regfile.sv
// Pointer and length storage.
// Assumes a register write to a pointer outranks an update of it.
module agen_regfile #(
    parameter int AW   = 8,
    parameter int NPTR = 2,
    parameter int NLEN = 2,
    localparam int PW  = (NPTR > 1) ? $clog2(NPTR) : 1,
    localparam int LW  = (NLEN > 1) ? $clog2(NLEN) : 1,
    localparam int IW  = (PW > LW) ? PW : LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_kind,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic          upd_en,
    input  logic [PW-1:0] upd_idx,
    input  logic [AW-1:0] upd_val,
    output logic [AW-1:0] ptr_q [NPTR],
    output logic [AW-1:0] len_q [NLEN]
);
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        // Load or post-modify one pointer.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q[g] <= '0;
            else if (wr_en && !wr_kind && wr_idx == IW'(g))
                ptr_q[g] <= wr_data;
            else if (upd_en && upd_idx == PW'(g))
                ptr_q[g] <= upd_val;
        end
    end

    for (genvar g = 0; g < NLEN; g++) begin : g_len
        // Load one buffer length register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                len_q[g] <= '0;
            else if (wr_en && wr_kind && wr_idx == IW'(g))
                len_q[g] <= wr_data;
        end
    end
endmodule

// File: rtl/ptr_agen.sv
// Top of the address generator: drives the selected pointer as the
// address and post-modifies it at the next edge when an access is made.
// Assumes acc_ptr and acc_nsel stay within NPTR and NLEN.
module ptr_agen #(
    parameter int AW   = 8,
    parameter int NPTR = 2,
    parameter int NLEN = 2,
    localparam int PW  = (NPTR > 1) ? $clog2(NPTR) : 1,
    localparam int LW  = (NLEN > 1) ? $clog2(NLEN) : 1,
    localparam int IW  = (PW > LW) ? PW : LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_kind,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic          acc_en,
    input  logic [PW-1:0] acc_ptr,
    input  logic [2:0]    acc_mode,
    input  logic [LW-1:0] acc_nsel,
    output logic [AW-1:0] acc_addr
);
    logic [AW-1:0] ptr_q [NPTR];
    logic [AW-1:0] len_q [NLEN];
    logic [AW-1:0] len_sel;
    logic [AW-1:0] nxt_val;

    // Route the chosen pointer and length to the step logic.
    always_comb begin
        acc_addr = ptr_q[acc_ptr];
        len_sel  = len_q[acc_nsel];
    end

    agen_step #(.AW(AW)) u_step (
        .cur  (acc_addr),
        .mode (acc_mode),
        .len  (len_sel),
        .nxt  (nxt_val)
    );

    agen_regfile #(.AW(AW), .NPTR(NPTR), .NLEN(NLEN)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_kind (wr_kind),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .upd_en  (acc_en),
        .upd_idx (acc_ptr),
        .upd_val (nxt_val),
        .ptr_q   (ptr_q),
        .len_q   (len_q)
    );
endmodule

// File: rtl/agen_chk.sv
// Cycle checks for ptr_agen, attached by bind.
// Assumes it sees the pointer storage of the top module.
module agen_chk #(
    parameter int AW   = 8,
    parameter int NPTR = 2,
    parameter int NLEN = 2,
    localparam int PW  = (NPTR > 1) ? $clog2(NPTR) : 1,
    localparam int LW  = (NLEN > 1) ? $clog2(NLEN) : 1,
    localparam int IW  = (PW > LW) ? PW : LW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          wr_kind,
    input logic [IW-1:0] wr_idx,
    input logic [AW-1:0] wr_data,
    input logic          acc_en,
    input logic [PW-1:0] acc_ptr,
    input logic [2:0]    acc_mode,
    input logic [AW-1:0] acc_addr,
    input logic [AW-1:0] ptr_q [NPTR]
);
    logic [PW-1:0] last_ptr;
    logic [IW-1:0] last_widx;
    logic          hit;

    // Remember which pointer was accessed and which was written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_ptr  <= '0;
            last_widx <= '0;
        end else begin
            last_ptr  <= acc_ptr;
            last_widx <= wr_idx;
        end
    end

    // Flag a pointer write aimed at the accessed pointer.
    always_comb hit = wr_en && !wr_kind && (int'(wr_idx) == int'(acc_ptr));

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> acc_addr == '0);

    // R3
    plain_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && acc_mode == 3'd1 && !hit |=> ptr_q[last_ptr] == $past(acc_addr) + 1'b1);

    // R4
    plain_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && acc_mode == 3'd2 && !hit |=> ptr_q[last_ptr] == $past(acc_addr) - 1'b1);

    // R8
    hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && (acc_mode == 3'd0 || acc_mode > 3'd4) && !hit |=> ptr_q[last_ptr] == $past(acc_addr));

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_kind |=> ptr_q[last_widx] == $past(wr_data));

    for (genvar g = 0; g < NPTR; g++) begin : g_other
        // R10
        other_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            acc_en && !wr_en && int'(acc_ptr) != g |=> $stable(ptr_q[g]));
    end
endmodule

bind ptr_agen agen_chk #(.AW(AW), .NPTR(NPTR), .NLEN(NLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_kind  (wr_kind),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .acc_en   (acc_en),
    .acc_ptr  (acc_ptr),
    .acc_mode (acc_mode),
    .acc_addr (acc_addr),
    .ptr_q    (ptr_q)
);

// File: tb/ptr_agen_bench.sv
// Directed bench for ptr_agen; one task per scenario.
module ptr_agen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_kind = 1'b0;
    logic       wr_idx = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       acc_en = 1'b0;
    logic       acc_ptr = 1'b0;
    logic [2:0] acc_mode = 3'd0;
    logic       acc_nsel = 1'b0;
    logic [7:0] acc_addr;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    ptr_agen u_ptr_agen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .acc_en(acc_en),
        .acc_ptr(acc_ptr), .acc_mode(acc_mode), .acc_nsel(acc_nsel),
        .acc_addr(acc_addr)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // Independent model of circular stepping.
    function automatic logic [7:0] model_mod(input logic [7:0] p, input int n, input bit up);
        int b, off, base;
        if (n < 2) return p;
        b = 1;
        while (b < n) b = b * 2;
        off  = int'(p) % b;
        base = int'(p) - off;
        if (up) return (off >= n - 1) ? 8'(base) : p + 8'd1;
        return (off == 0) ? 8'(base + n - 1) : p - 8'd1;
    endfunction

    task automatic do_write(input logic kind, input logic idx, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = kind; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_access(input logic p, input logic [2:0] m, input logic ns,
                             input logic en, output logic [7:0] pre);
        @(negedge clk);
        acc_en = en; acc_ptr = p; acc_mode = m; acc_nsel = ns;
        #1 pre = acc_addr;
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic peek(input logic p, output logic [7:0] v);
        acc_ptr = p;
        #1 v = acc_addr;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        peek(1'b0, v); check("R1 ptr0", v, 8'h00);
        peek(1'b1, v); check("R1 ptr1", v, 8'h00);
    endtask

    task automatic t_plain;
        logic [7:0] v;
        do_write(1'b0, 1'b0, 8'hFE);
        do_access(1'b0, 3'd1, 1'b0, 1'b1, v); check("R2 pre-address", v, 8'hFE);
        do_access(1'b0, 3'd1, 1'b0, 1'b1, v); check("R3 step up", v, 8'hFF);
        peek(1'b0, v); check("R3 wrap to 00", v, 8'h00);
        do_write(1'b0, 1'b1, 8'h01);
        do_access(1'b1, 3'd2, 1'b0, 1'b1, v); check("R4 pre", v, 8'h01);
        do_access(1'b1, 3'd2, 1'b0, 1'b1, v); check("R4 step down", v, 8'h00);
        peek(1'b1, v); check("R4 wrap to FF", v, 8'hFF);
        peek(1'b0, v); check("R10 ptr0 untouched", v, 8'h00);
    endtask

    task automatic t_mod_inc;
        logic [7:0] v;
        do_write(1'b1, 1'b0, 8'd5);
        do_write(1'b1, 1'b1, 8'd12);
        do_write(1'b0, 1'b0, 8'h23);
        do_write(1'b0, 1'b1, 8'h4A);
        do_access(1'b0, 3'd3, 1'b0, 1'b1, v); check("R5 N=5 pre", v, 8'h23);
        do_access(1'b0, 3'd3, 1'b0, 1'b1, v); check("R5 N=5 last", v, 8'h24);
        peek(1'b0, v); check("R5 N=5 wrap to base", v, 8'h20);
        do_access(1'b1, 3'd3, 1'b1, 1'b1, v); check("R5 N=12 pre", v, 8'h4A);
        do_access(1'b1, 3'd3, 1'b1, 1'b1, v); check("R5 N=12 last", v, 8'h4B);
        peek(1'b1, v); check("R5 N=12 wrap to base", v, 8'h40);
    endtask

    task automatic t_mod_dec;
        logic [7:0] v;
        do_write(1'b0, 1'b1, 8'h41);
        do_access(1'b1, 3'd4, 1'b1, 1'b1, v); check("R6 N=12 pre", v, 8'h41);
        do_access(1'b1, 3'd4, 1'b1, 1'b1, v); check("R6 N=12 at base", v, 8'h40);
        peek(1'b1, v); check("R6 N=12 wrap to top", v, 8'h4B);
        do_write(1'b1, 1'b0, 8'd3);
        do_write(1'b0, 1'b0, 8'h80);
        do_access(1'b0, 3'd4, 1'b0, 1'b1, v);
        peek(1'b0, v); check("R6 N=3 wrap to top", v, 8'h82);
    endtask

    task automatic t_sweep;
        int lens [5] = '{3, 5, 8, 13, 100};
        logic [7:0] starts [5] = '{8'h11, 8'h64, 8'hF9, 8'h37, 8'h05};
        logic [7:0] v, exp;
        foreach (lens[i]) begin
            do_write(1'b1, 1'b1, 8'(lens[i]));
            do_write(1'b0, 1'b0, starts[i]);
            exp = starts[i];
            for (int k = 0; k < 2 * lens[i] + 2; k++) begin
                bit up = (k % 3) != 2;
                do_access(1'b0, up ? 3'd3 : 3'd4, 1'b1, 1'b1, v);
                check(up ? "R5 sweep" : "R6 sweep", v, exp);
                exp = model_mod(exp, lens[i], up);
            end
            peek(1'b0, v); check("R2 sweep final", v, exp);
        end
    endtask

    task automatic t_small_len;
        logic [7:0] v;
        do_write(1'b1, 1'b0, 8'd0);
        do_write(1'b1, 1'b1, 8'd1);
        do_write(1'b0, 1'b0, 8'h77);
        do_access(1'b0, 3'd3, 1'b0, 1'b1, v);
        do_access(1'b0, 3'd4, 1'b0, 1'b1, v);
        peek(1'b0, v); check("R7 N=0", v, 8'h77);
        do_access(1'b0, 3'd3, 1'b1, 1'b1, v);
        do_access(1'b0, 3'd4, 1'b1, 1'b1, v);
        peek(1'b0, v); check("R7 N=1", v, 8'h77);
    endtask

    task automatic t_hold;
        logic [7:0] v;
        do_write(1'b0, 1'b1, 8'h9C);
        do_access(1'b1, 3'd0, 1'b0, 1'b1, v);
        peek(1'b1, v); check("R8 code 0", v, 8'h9C);
        for (int c = 5; c < 8; c++) begin
            do_access(1'b1, 3'(c), 1'b0, 1'b1, v);
            peek(1'b1, v); check("R8 codes 5-7", v, 8'h9C);
        end
        do_access(1'b1, 3'd1, 1'b0, 1'b0, v);
        peek(1'b1, v); check("R8 acc_en low", v, 8'h9C);
    endtask

    task automatic t_collide;
        logic [7:0] v;
        do_write(1'b0, 1'b0, 8'h20);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = 1'b0; wr_idx = 1'b0; wr_data = 8'h55;
        acc_en = 1'b1; acc_ptr = 1'b0; acc_mode = 3'd1;
        @(negedge clk);
        wr_en = 1'b0; acc_en = 1'b0;
        peek(1'b0, v); check("R9 write wins", v, 8'h55);
        wr_en = 1'b1; wr_kind = 1'b0; wr_idx = 1'b1; wr_data = 8'h10;
        acc_en = 1'b1; acc_ptr = 1'b0; acc_mode = 3'd1;
        @(negedge clk);
        wr_en = 1'b0; acc_en = 1'b0;
        peek(1'b0, v); check("R10 accessed ptr", v, 8'h56);
        peek(1'b1, v); check("R10 other ptr written", v, 8'h10);
        do_write(1'b1, 1'b0, 8'd7);
        do_write(1'b0, 1'b0, 8'h36);
        do_access(1'b0, 3'd3, 1'b0, 1'b1, v);
        peek(1'b0, v); check("R9 length write", v, 8'h30);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_mod_inc();
        t_mod_dec();
        t_sweep();
        t_small_len();
        t_hold();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule